// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt events from twenty peripheral sources and one watchdog source and offers a single interrupt at a time to a CPU core. Each peripheral event is a one-cycle pulse. The pulse sets a sticky request bit. The request bits live in five 4-bit request registers, and each request register has a matching 4-bit enable register. A request competes for the CPU only when both its request bit and its enable bit are set. A master enable flag also gates all peripheral requests.

The watchdog request is not maskable. It is offered whatever the enable registers and the master enable hold, and it always wins. Among the other sources, priority is fixed by source number.

The CPU sees a request line and a 5-bit source index. It accepts an interrupt by pulsing an acknowledge for one cycle. Acceptance clears the request bit of that source and drops the master enable. The enable registers are not changed. Software reaches the registers through a nibble-wide bus with byte addresses.

Top module: `prio_int_ctrl`

## Requirements
- R1: After reset, every enable bit, every request bit, the master enable and the pending watchdog request are 0, and `cpu_irq` is 0.
- R2: Enable register g (g = 0..4) is at byte address 0x50+g. Request register g is at 0x58+g. The master enable is bit 0 at 0x5F. Bit b of register g belongs to source k = 4*g + b. Reads of any other address return 0.
- R3: A pulse on `src_pulse[k]` sets request bit k. A bus write to a request register clears every bit written as 0 and leaves every bit written as 1 unchanged.
- R4: A peripheral source is offered to the CPU only when its request bit, its enable bit and the master enable are all 1.
- R5: A `wdt_pulse` makes a watchdog request pending. While it is pending, `cpu_irq` is 1 and `cpu_idx` is 0, whatever the enable registers and the master enable hold.
- R6: When no watchdog request is pending, `cpu_idx` is k+1, where k is the lowest-numbered source whose request bit and enable bit are both 1.
- R7: An accept is `cpu_ack` high while `cpu_irq` is high. On the next cycle the master enable is 0 and the accepted request is cleared. Every other pending request stays pending.
- R8: An accept leaves all enable registers unchanged.
- R9: If a software write of 1 to the master enable and an accept happen in the same cycle, the master enable ends as 0.
- R10: A peripheral pulse in the same cycle as a software clear of the same request bit leaves that bit set.
- R11: A `cpu_ack` while `cpu_irq` is 0 has no effect: the master enable and all request bits are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pulse | input | 20 | One-cycle event pulses from the peripheral sources, one bit per source |
| wdt_pulse | input | 1 | One-cycle watchdog event pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for `bus_addr` (combinational) |
| cpu_irq | output | 1 | An interrupt is offered to the CPU |
| cpu_idx | output | 5 | Index of the offered source: 0 for the watchdog, otherwise peripheral source number + 1 |
| cpu_ack | input | 1 | One-cycle acknowledge from the CPU |

## Verification
The hardest cases to reach from the ports are collisions within a single clock cycle:
- a master-enable write of 1 arriving together with an accept;
- a peripheral pulse arriving together with a software clear of the same bit.

The bench creates each collision by driving both inputs on the same falling edge. It then reads the affected register back over the bus.

Acceptance of a lower-priority source depends on the master enable having been cleared and then set again. The bench therefore walks through three pending sources in turn, rewriting the master enable between acknowledges. It checks that the lower-priority requests survive each accept.

// File: rtl/prio_int_pkg.sv
package prio_int_pkg;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_EN,
    SEL_REQ,
    SEL_MASTER
  } reg_sel_e;

  function automatic logic addr_in_window(input logic [7:0] addr,
                                          input logic [7:0] base,
                                          input int unsigned count);
    return (addr >= base) && ({24'd0, addr} < {24'd0, base} + count);
  endfunction

endpackage

// File: rtl/int_req_bank.sv
module int_req_bank #(
  parameter int GROUPS = 5,
  parameter int GW     = 4,
  localparam int NSRC  = GROUPS * GW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   pulse,
  input  logic [GROUPS-1:0] en_wr,
  input  logic [GROUPS-1:0] req_wr,
  input  logic [GW-1:0]     wdata,
  input  logic [NSRC-1:0]   ack_clr,
  output logic [NSRC-1:0]   en_flat,
  output logic [NSRC-1:0]   req_flat
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GW-1:0] en_q, req_q, sw_clr, hw_clr, set_v;

    assign set_v  = pulse[g*GW +: GW];
    assign hw_clr = ack_clr[g*GW +: GW];
    assign sw_clr = req_wr[g] ? ~wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= '0;
        req_q <= '0;
      end else begin
        if (en_wr[g]) en_q <= wdata;
        req_q <= (req_q & ~sw_clr & ~hw_clr) | set_v;
      end
    end

    assign en_flat[g*GW +: GW]  = en_q;
    assign req_flat[g*GW +: GW] = req_q;
  end

endmodule

// File: rtl/int_master_ctl.sv
module int_master_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic accept,
  input  logic wdt_pulse,
  input  logic wdt_taken,
  output logic master_en,
  output logic wdt_pend
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      wdt_pend  <= 1'b0;
    end else begin
      if (accept)     master_en <= 1'b0;
      else if (sw_wr) master_en <= sw_val;
      wdt_pend <= wdt_pulse | (wdt_pend & ~wdt_taken);
    end
  end

endmodule

// File: rtl/int_prio_pick.sv
module int_prio_pick #(
  parameter int NSRC   = 20,
  localparam int IDX_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]  req,
  input  logic [NSRC-1:0]  en,
  input  logic             master_en,
  input  logic             wdt_pend,
  output logic [NSRC-1:0]  masked,
  output logic             irq,
  output logic [IDX_W-1:0] idx
);

  function automatic logic [IDX_W-1:0] lowest_plus1(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i + 1);
    return r;
  endfunction

  assign masked = req & en;
  assign irq    = wdt_pend | (master_en & (|masked));
  assign idx    = wdt_pend ? '0 : lowest_plus1(masked);

endmodule

// File: rtl/prio_int_ctrl.sv
module prio_int_ctrl #(
  parameter int          GROUPS    = 5,
  parameter int          GW        = 4,
  parameter logic [7:0]  EN_BASE   = 8'h50,
  parameter logic [7:0]  REQ_BASE  = 8'h58,
  parameter logic [7:0]  MASTER_AD = 8'h5F,
  localparam int NSRC  = GROUPS * GW,
  localparam int IDX_W = $clog2(NSRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [19:0]      src_pulse,
  input  logic             wdt_pulse,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [3:0]       bus_wdata,
  output logic [3:0]       bus_rdata,
  output logic             cpu_irq,
  output logic [4:0]       cpu_idx,
  input  logic             cpu_ack
);
  import prio_int_pkg::*;

  logic [NSRC-1:0]   en_flat, req_flat, masked_vec, ack_clr_vec;
  logic [GROUPS-1:0] en_wr_vec, req_wr_vec;
  logic              master_en, wdt_pend, accept_fire, master_wr, en_wr_any;
  logic [IDX_W-1:0]  idx_w;
  logic [7:0]        grp_off;
  reg_sel_e          rd_sel;

  always_comb begin
    if (bus_addr == MASTER_AD)                             rd_sel = SEL_MASTER;
    else if (addr_in_window(bus_addr, EN_BASE, GROUPS))    rd_sel = SEL_EN;
    else if (addr_in_window(bus_addr, REQ_BASE, GROUPS))   rd_sel = SEL_REQ;
    else                                                   rd_sel = SEL_NONE;
  end

  assign grp_off = (rd_sel == SEL_EN) ? bus_addr - EN_BASE : bus_addr - REQ_BASE;

  for (genvar g = 0; g < GROUPS; g++) begin : g_dec
    assign en_wr_vec[g]  = bus_wr && (rd_sel == SEL_EN)  && (grp_off == 8'(g));
    assign req_wr_vec[g] = bus_wr && (rd_sel == SEL_REQ) && (grp_off == 8'(g));
  end

  assign master_wr   = bus_wr && (rd_sel == SEL_MASTER);
  assign en_wr_any   = |en_wr_vec;
  assign accept_fire = cpu_ack && cpu_irq;
  assign ack_clr_vec = (accept_fire && idx_w != '0) ? (NSRC'(1) << (idx_w - 1'b1)) : '0;

  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grp_off == 8'(g)) begin
        if (rd_sel == SEL_EN)  bus_rdata = en_flat[g*GW +: GW];
        if (rd_sel == SEL_REQ) bus_rdata = req_flat[g*GW +: GW];
      end
    end
    if (rd_sel == SEL_MASTER) bus_rdata = {3'b000, master_en};
  end

  int_req_bank #(.GROUPS(GROUPS), .GW(GW)) u_bank (
    .clk(clk), .rst_n(rst_n), .pulse(src_pulse[NSRC-1:0]),
    .en_wr(en_wr_vec), .req_wr(req_wr_vec), .wdata(bus_wdata),
    .ack_clr(ack_clr_vec), .en_flat(en_flat), .req_flat(req_flat)
  );

  int_master_ctl u_master (
    .clk(clk), .rst_n(rst_n), .sw_wr(master_wr), .sw_val(bus_wdata[0]),
    .accept(accept_fire), .wdt_pulse(wdt_pulse),
    .wdt_taken(accept_fire && idx_w == '0),
    .master_en(master_en), .wdt_pend(wdt_pend)
  );

  int_prio_pick #(.NSRC(NSRC)) u_pick (
    .req(req_flat), .en(en_flat), .master_en(master_en), .wdt_pend(wdt_pend),
    .masked(masked_vec), .irq(cpu_irq), .idx(idx_w)
  );

  assign cpu_idx = 5'(idx_w);

endmodule

// File: rtl/prio_int_checker.sv
module prio_int_checker #(
  parameter int NSRC = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            accept_fire,
  input logic            en_wr_any,
  input logic            master_wr,
  input logic [NSRC-1:0] en_flat,
  input logic            master_en,
  input logic            wdt_pend,
  input logic            cpu_irq,
  input logic            cpu_ack,
  input logic [4:0]      cpu_idx
);

  p_wdt_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_pend |-> (cpu_irq && cpu_idx == 5'd0));

  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_idx != 5'd0) |-> master_en);

  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (cpu_idx <= 5'(NSRC)));

  p_master_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |=> !master_en);

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_fire && !en_wr_any) |=> $stable(en_flat));

  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_irq && !master_wr) |=> $stable(master_en));

endmodule

bind prio_int_ctrl prio_int_checker #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept_fire(accept_fire), .en_wr_any(en_wr_any),
  .master_wr(master_wr), .en_flat(en_flat), .master_en(master_en),
  .wdt_pend(wdt_pend), .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .cpu_idx(cpu_idx)
);

// File: tb/prio_int_ctrl_tb.sv
`timescale 1ns/1ps
module prio_int_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] src_pulse = '0;
  logic        wdt_pulse = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_wdata = '0;
  logic [3:0]  bus_rdata;
  logic        cpu_irq;
  logic [4:0]  cpu_idx;
  logic        cpu_ack = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  prio_int_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wdt_pulse(wdt_pulse),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .cpu_idx(cpu_idx), .cpu_ack(cpu_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic pulse_src(input int k);
    @(negedge clk); src_pulse[k] = 1'b1;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
  endtask

  task automatic clear_all();
    for (int g = 0; g < 5; g++) begin
      wr(8'h58 + 8'(g), 4'h0);
      wr(8'h50 + 8'(g), 4'h0);
    end
    wr(8'h5F, 4'h0);
  endtask

  task automatic t_reset();
    int v;
    for (int g = 0; g < 5; g++) begin
      rd(8'h50 + 8'(g), v); chk("R1 enable reset", v, 0);
      rd(8'h58 + 8'(g), v); chk("R1 request reset", v, 0);
    end
    rd(8'h5F, v); chk("R1 master reset", v, 0);
    chk("R1 irq reset", int'(cpu_irq), 0);
    rd(8'h40, v); chk("R2 unmapped read", v, 0);
  endtask

  task automatic t_req_rw();
    int v;
    pulse_src(6);
    rd(8'h59, v); chk("R3 pulse sets IRQ1 bit2", v, 4);
    chk("R4 not offered while disabled", int'(cpu_irq), 0);
    wr(8'h59, 4'b0100);
    rd(8'h59, v); chk("R3 write 1 keeps", v, 4);
    wr(8'h59, 4'b1011);
    rd(8'h59, v); chk("R3 write 0 clears", v, 0);
    wr(8'h53, 4'hA);
    rd(8'h53, v); chk("R2 IE3 read back", v, 10);
  endtask

  task automatic t_mask();
    int v;
    clear_all();
    pulse_src(6);
    wr(8'h51, 4'b0100);
    chk("R4 master off blocks", int'(cpu_irq), 0);
    wr(8'h5F, 4'h1);
    chk("R4 offered when all set", int'(cpu_irq), 1);
    chk("R6 idx for source 6", int'(cpu_idx), 7);
    wr(8'h51, 4'b0000);
    chk("R4 enable off blocks", int'(cpu_irq), 0);
  endtask

  task automatic t_priority();
    int v;
    clear_all();
    pulse_src(6); pulse_src(13); pulse_src(19);
    for (int g = 0; g < 5; g++) wr(8'h50 + 8'(g), 4'hF);
    wr(8'h5F, 4'h1);
    chk("R6 lowest source wins", int'(cpu_idx), 7);
    ack();
    chk("R7 master cleared stops irq", int'(cpu_irq), 0);
    rd(8'h5F, v); chk("R7 master reads 0", v, 0);
    rd(8'h59, v); chk("R7 accepted bit cleared", v, 0);
    rd(8'h5B, v); chk("R7 source 13 still pending", v, 2);
    rd(8'h5C, v); chk("R7 source 19 still pending", v, 8);
    for (int g = 0; g < 5; g++) begin
      rd(8'h50 + 8'(g), v); chk("R8 enable unchanged", v, 15);
    end
    wr(8'h5F, 4'h1);
    chk("R6 next source", int'(cpu_idx), 14);
    ack();
    wr(8'h5F, 4'h1);
    chk("R6 last source", int'(cpu_idx), 20);
    ack();
    chk("R7 all drained", int'(cpu_irq), 0);
  endtask

  task automatic t_wdt();
    int v;
    clear_all();
    pulse_src(0);
    @(negedge clk); wdt_pulse = 1'b1;
    @(negedge clk); wdt_pulse = 1'b0;
    chk("R5 wdt offered with all masks 0", int'(cpu_irq), 1);
    chk("R5 wdt idx 0", int'(cpu_idx), 0);
    wr(8'h50, 4'h1); wr(8'h5F, 4'h1);
    chk("R5 wdt beats source 0", int'(cpu_idx), 0);
    ack();
    rd(8'h5F, v); chk("R7 master cleared by wdt accept", v, 0);
    chk("R7 wdt cleared", int'(cpu_irq), 0);
    rd(8'h58, v); chk("R7 source 0 kept", v, 1);
  endtask

  task automatic t_collide();
    int v;
    clear_all();
    @(negedge clk); wdt_pulse = 1'b1;
    @(negedge clk); wdt_pulse = 1'b0;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h5F; bus_wdata = 4'h1; cpu_ack = 1'b1;
    @(negedge clk); bus_wr = 1'b0; cpu_ack = 1'b0;
    rd(8'h5F, v); chk("R9 set and accept gives 0", v, 0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h58; bus_wdata = 4'h0; src_pulse[2] = 1'b1;
    @(negedge clk); bus_wr = 1'b0; src_pulse = '0;
    rd(8'h58, v); chk("R10 pulse beats clear", v, 4);
  endtask

  task automatic t_idle_ack();
    int v;
    clear_all();
    pulse_src(9);
    wr(8'h5F, 4'h1);
    chk("R11 irq idle", int'(cpu_irq), 0);
    ack();
    rd(8'h5F, v); chk("R11 master kept", v, 1);
    rd(8'h5A, v); chk("R11 request kept", v, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_req_rw();
    t_mask();
    t_priority();
    t_wdt();
    t_collide();
    t_idle_ack();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule